// File: doc/BRIEF.md
# Bus Parity and ECC Checker

This block sits beside a system bus interface and watches two streams of traffic. The first is the address/command phase and the second is the data phase. It does not drive the bus and never alters what it sees. Every data word leaves through a registered pass-through path exactly as it arrived. The block's only job is to find faults and report them, so that a failure can be traced to the interface where it first showed up. Repair is left to whoever finally consumes the data.

On the address phase, two even-parity bits are checked separately. One covers the address field and the other covers the command field. Each failure is flagged on its own line.

On the data phase, each 64-bit word arrives with an 8-bit check code from an extended Hamming (72,64) code. The block computes the syndrome and sorts the result into one of four classes: clean, single-bit error, double-bit error or multi-bit error. Eight data beats make up one 64-byte block. After the eighth beat the block gives a per-block summary. It also keeps the syndrome and beat index of the first faulty beat of the block. Sticky flags gather every error class until a clear input is pulsed.

Top module: `bus_integrity_checker`

## Requirements
- R1: While reset is low, and on the first cycle after it, every output is zero.
- R2: The address is protected by even parity: the XOR of `addr` and `addr_par` is 0 when healthy. When `addr_valid` is high and that XOR is 1, `addr_perr` is high for exactly the next cycle. When `addr_valid` is low, the parity inputs have no effect on any output.
- R3: The command is protected by its own even parity, using `cmd` with `cmd_par`. `cmd_perr` is driven only by that check, one cycle after `addr_valid`, and is independent of the address check.
- R4: One cycle after `data_valid`, `data_out_valid` is high and `data_out` equals the received `data` bit for bit, even when that word is faulty. `data_out` holds its value between beats.
- R5: Code layout. Hamming positions run from 1 to 71. Check bit k (for k from 0 to 6) sits at position 2^k. Data bit i sits at the i-th position, counting from 0, that is not a power of two, so data bit 0 is at position 3 and data bit 5 is at position 10. Check bit 7 is the overall even parity over all 72 bits. The syndrome bit k is the XOR of every bit whose position has bit k set, so a zero syndrome with even overall parity means a clean word.
- R6: A beat with odd overall parity and a syndrome of 71 or less pulses `sbe` one cycle after `data_valid`. `err_pos` then carries the faulty position. Position 0 means check bit 7. At all other times `err_pos` is 0.
- R7: A beat with even overall parity and a nonzero syndrome pulses `dbe`. This covers every two-bit error and also those four-bit errors whose syndrome is nonzero.
- R8: A beat with odd overall parity and a syndrome above 71 pulses `mbe`. At most one of `sbe`, `dbe` and `mbe` is high in any cycle, and none of them responds when `data_valid` is low.
- R9: The five sticky flags (address parity, command parity, single, double, multi) set together with their pulse and hold until `clr` is high. If `clr` and a new error arrive in the same cycle, the flag ends up set.
- R10: Beats are counted in groups of `BEATS`, and idle cycles between beats are allowed. `blk_done` pulses together with the flags of the last beat of a group. `blk_err` (any error in the group) and `blk_uncorr` (any double or multi error in the group) update with it and hold until the next group completes.
- R11: `first_syn` holds the syndrome of the first faulty beat of the current group as {overall parity, 7-bit syndrome}. `first_beat` holds that beat's index and `first_vld` is set with them. Later faulty beats in the group leave all three unchanged. The first beat of a new group clears them, unless that beat is faulty itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clears the sticky flags |
| addr_valid | input | 1 | Address/command phase strobe |
| addr | input | ADDR_W (40) | Address field |
| addr_par | input | 1 | Even parity bit for `addr` |
| cmd | input | CMD_W (8) | Command and associated fields |
| cmd_par | input | 1 | Even parity bit for `cmd` |
| data_valid | input | 1 | Data beat strobe |
| data | input | 64 | Data word |
| data_ecc | input | 8 | Check code of the data word |
| data_out_valid | output | 1 | Pass-through beat strobe |
| data_out | output | 64 | Unmodified data word |
| addr_perr | output | 1 | Address parity error pulse |
| cmd_perr | output | 1 | Command parity error pulse |
| sbe | output | 1 | Single-bit error pulse |
| dbe | output | 1 | Double-bit error pulse |
| mbe | output | 1 | Multi-bit error pulse |
| err_pos | output | 7 | Faulty position of a single-bit error |
| stk_addr_perr | output | 1 | Sticky address parity error |
| stk_cmd_perr | output | 1 | Sticky command parity error |
| stk_sbe | output | 1 | Sticky single-bit error |
| stk_dbe | output | 1 | Sticky double-bit error |
| stk_mbe | output | 1 | Sticky multi-bit error |
| blk_done | output | 1 | Group-complete pulse |
| blk_err | output | 1 | Last group had any error |
| blk_uncorr | output | 1 | Last group had an uncorrectable error |
| first_vld | output | 1 | A faulty beat was captured in the group |
| first_syn | output | 8 | Syndrome of the first faulty beat |
| first_beat | output | $clog2(BEATS) (3) | Index of the first faulty beat |

## Verification
Every result sits behind a single register stage, so each one is due in the cycle right after the strobe that caused it. This covers the parity pulses, the class pulses, `err_pos`, the pass-through word, the sticky flags, the group summary and the first-failure capture.

The bench runs a behavioural model that takes its inputs on the same rising edge as the design. It compares every output on the falling edge that follows, which is exactly when the registered values are due.

The directed checks come back from each stimulus task on that same falling edge. They compare against constants worked out by hand from the code layout, such as position 10 for data bit 5 and syndrome 88 for the triple-check-bit fault.

// File: rtl/bic_pkg.sv
package bic_pkg;

    localparam int WORD_W  = 64;
    localparam int CHK_W   = 8;
    localparam int POS_W   = 7;
    localparam int MAX_POS = 71;

    typedef enum logic [1:0] {
        ECC_CLEAN = 2'd0,
        ECC_SBE   = 2'd1,
        ECC_DBE   = 2'd2,
        ECC_MBE   = 2'd3
    } ecc_class_e;

    // Hamming position of data bit idx: the idx-th non power of two from 3
    function automatic logic [POS_W-1:0] word_bit_pos(input int idx);
        int n;
        logic [POS_W-1:0] r;
        n = 0;
        r = '0;
        for (int p = 1; p < (1 << POS_W); p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) r = POS_W'(p);
                n++;
            end
        end
        return r;
    endfunction

    // Data bits that feed syndrome bit k
    function automatic logic [WORD_W-1:0] syn_mask(input int k);
        logic [WORD_W-1:0] m;
        logic [POS_W-1:0]  t;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            t    = word_bit_pos(i);
            m[i] = t[k];
        end
        return m;
    endfunction

endpackage

// File: rtl/bic_parity_check.sv
module bic_parity_check #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    input  logic         par,
    output logic         bad
);
    // even parity: the XOR over field and parity bit is zero when healthy
    assign bad = ^{vec, par};
endmodule

// File: rtl/bic_ecc_syndrome.sv
module bic_ecc_syndrome
    import bic_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [CHK_W-1:0]  chk,
    output logic [POS_W-1:0]  syn,
    output logic              ovr,
    output ecc_class_e        cls,
    output logic [POS_W-1:0]  pos
);
    for (genvar k = 0; k < POS_W; k++) begin : g_syn
        localparam logic [WORD_W-1:0] MASK = syn_mask(k);
        assign syn[k] = (^(word & MASK)) ^ chk[k];
    end

    assign ovr = (^word) ^ (^chk);

    always_comb begin
        cls = ECC_CLEAN;
        pos = '0;
        if (ovr) begin
            if (syn <= POS_W'(MAX_POS)) begin
                cls = ECC_SBE;
                pos = syn;
            end else begin
                cls = ECC_MBE;
            end
        end else if (syn != '0) begin
            cls = ECC_DBE;
        end
    end

    // R8: classes are exclusive; a clean class means a clean syndrome
    always_comb begin
        a_clean_r5: assert ((cls != ECC_CLEAN) || (syn == '0 && !ovr))
            else $error("clean class with nonzero syndrome");
    end
endmodule

// File: rtl/bic_block_tracker.sv
module bic_block_tracker #(
    parameter  int BEATS  = 8,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic              beat_err,
    input  logic              beat_uncorr,
    input  logic [7:0]        beat_syn,
    output logic              blk_done,
    output logic              blk_err,
    output logic              blk_uncorr,
    output logic              first_vld,
    output logic [7:0]        first_syn,
    output logic [BEAT_W-1:0] first_beat
);
    typedef struct packed {
        logic [BEAT_W-1:0] cnt;
        logic              acc_err;
        logic              acc_unc;
        logic              done;
        logic              berr;
        logic              bunc;
        logic              fvld;
        logic [7:0]        fsyn;
        logic [BEAT_W-1:0] fbeat;
    } trk_t;

    trk_t s_d, s_q;
    logic starts_grp;
    logic prev_err, prev_unc;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        starts_grp = (s_q.cnt == '0);
        prev_err   = starts_grp ? 1'b0 : s_q.acc_err;
        prev_unc   = starts_grp ? 1'b0 : s_q.acc_unc;
        if (beat_valid) begin
            if (beat_err && !prev_err) begin
                s_d.fvld  = 1'b1;
                s_d.fsyn  = beat_syn;
                s_d.fbeat = s_q.cnt;
            end else if (starts_grp) begin
                s_d.fvld  = 1'b0;
                s_d.fsyn  = '0;
                s_d.fbeat = '0;
            end
            s_d.acc_err = prev_err | beat_err;
            s_d.acc_unc = prev_unc | beat_uncorr;
            if (s_q.cnt == BEAT_W'(BEATS - 1)) begin
                s_d.cnt  = '0;
                s_d.done = 1'b1;
                s_d.berr = s_d.acc_err;
                s_d.bunc = s_d.acc_unc;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign blk_done   = s_q.done;
    assign blk_err    = s_q.berr;
    assign blk_uncorr = s_q.bunc;
    assign first_vld  = s_q.fvld;
    assign first_syn  = s_q.fsyn;
    assign first_beat = s_q.fbeat;

    p_done_needs_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |=> !blk_done);

    p_uncorr_in_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blk_uncorr |-> blk_err);

    p_first_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && s_q.cnt != '0 && first_vld) |=> ($stable(first_syn) && $stable(first_beat) && first_vld));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |=> ($stable(first_vld) && $stable(first_syn)));
endmodule

// File: rtl/bus_integrity_checker.sv
module bus_integrity_checker
    import bic_pkg::*;
#(
    parameter  int ADDR_W = 40,
    parameter  int CMD_W  = 8,
    parameter  int BEATS  = 8,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_par,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              cmd_par,
    input  logic              data_valid,
    input  logic [63:0]       data,
    input  logic [7:0]        data_ecc,
    output logic              data_out_valid,
    output logic [63:0]       data_out,
    output logic              addr_perr,
    output logic              cmd_perr,
    output logic              sbe,
    output logic              dbe,
    output logic              mbe,
    output logic [6:0]        err_pos,
    output logic              stk_addr_perr,
    output logic              stk_cmd_perr,
    output logic              stk_sbe,
    output logic              stk_dbe,
    output logic              stk_mbe,
    output logic              blk_done,
    output logic              blk_err,
    output logic              blk_uncorr,
    output logic              first_vld,
    output logic [7:0]        first_syn,
    output logic [BEAT_W-1:0] first_beat
);
    typedef struct packed {
        logic              a_perr;
        logic              c_perr;
        logic              sbe;
        logic              dbe;
        logic              mbe;
        logic [POS_W-1:0]  pos;
        logic              st_a;
        logic              st_c;
        logic              st_s;
        logic              st_d;
        logic              st_m;
        logic              dvld;
        logic [WORD_W-1:0] dword;
    } chk_t;

    chk_t s_d, s_q;

    logic             a_bad, c_bad;
    logic [POS_W-1:0] syn;
    logic             ovr;
    ecc_class_e       cls;
    logic [POS_W-1:0] pos;

    bic_parity_check #(.W(ADDR_W)) i_addr_par (.vec(addr), .par(addr_par), .bad(a_bad));
    bic_parity_check #(.W(CMD_W))  i_cmd_par  (.vec(cmd),  .par(cmd_par),  .bad(c_bad));

    bic_ecc_syndrome i_syn (
        .word(data), .chk(data_ecc), .syn(syn), .ovr(ovr), .cls(cls), .pos(pos)
    );

    bic_block_tracker #(.BEATS(BEATS)) i_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (data_valid),
        .beat_err   (cls != ECC_CLEAN),
        .beat_uncorr(cls == ECC_DBE || cls == ECC_MBE),
        .beat_syn   ({ovr, syn}),
        .blk_done   (blk_done),
        .blk_err    (blk_err),
        .blk_uncorr (blk_uncorr),
        .first_vld  (first_vld),
        .first_syn  (first_syn),
        .first_beat (first_beat)
    );

    always_comb begin
        s_d        = s_q;
        s_d.a_perr = addr_valid & a_bad;
        s_d.c_perr = addr_valid & c_bad;
        s_d.sbe    = data_valid && (cls == ECC_SBE);
        s_d.dbe    = data_valid && (cls == ECC_DBE);
        s_d.mbe    = data_valid && (cls == ECC_MBE);
        s_d.pos    = s_d.sbe ? pos : '0;
        s_d.dvld   = data_valid;
        if (data_valid) s_d.dword = data;
        if (clr) begin
            s_d.st_a = 1'b0;
            s_d.st_c = 1'b0;
            s_d.st_s = 1'b0;
            s_d.st_d = 1'b0;
            s_d.st_m = 1'b0;
        end
        s_d.st_a = s_d.st_a | s_d.a_perr;
        s_d.st_c = s_d.st_c | s_d.c_perr;
        s_d.st_s = s_d.st_s | s_d.sbe;
        s_d.st_d = s_d.st_d | s_d.dbe;
        s_d.st_m = s_d.st_m | s_d.mbe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr_perr      = s_q.a_perr;
    assign cmd_perr       = s_q.c_perr;
    assign sbe            = s_q.sbe;
    assign dbe            = s_q.dbe;
    assign mbe            = s_q.mbe;
    assign err_pos        = s_q.pos;
    assign stk_addr_perr  = s_q.st_a;
    assign stk_cmd_perr   = s_q.st_c;
    assign stk_sbe        = s_q.st_s;
    assign stk_dbe        = s_q.st_d;
    assign stk_mbe        = s_q.st_m;
    assign data_out_valid = s_q.dvld;
    assign data_out       = s_q.dword;

    p_addr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> !addr_perr);

    p_cmd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> !cmd_perr);

    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> (data_out_valid && data_out == $past(data)));

    p_class_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sbe, dbe, mbe}));

    p_class_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |=> !(sbe || dbe || mbe));

    p_pos_only_sbe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sbe |-> (err_pos == '0));

    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_sbe && !clr) |=> stk_sbe);

    p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dbe |-> stk_dbe);
endmodule

// File: tb/test_bus_integrity_checker.sv
module test_bus_integrity_checker;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 40;
    localparam int CMD_W      = 8;
    localparam int BEATS      = 8;
    localparam int WD_CYCLES  = 20000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              clr;
    logic              addr_valid;
    logic [ADDR_W-1:0] addr;
    logic              addr_par;
    logic [CMD_W-1:0]  cmd;
    logic              cmd_par;
    logic              data_valid;
    logic [63:0]       data;
    logic [7:0]        data_ecc;
    logic              data_out_valid;
    logic [63:0]       data_out;
    logic              addr_perr, cmd_perr, sbe, dbe, mbe;
    logic [6:0]        err_pos;
    logic              stk_addr_perr, stk_cmd_perr, stk_sbe, stk_dbe, stk_mbe;
    logic              blk_done, blk_err, blk_uncorr, first_vld;
    logic [7:0]        first_syn;
    logic [2:0]        first_beat;

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 0;

    bus_integrity_checker #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .BEATS(BEATS)) i_bus_integrity_checker (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .addr_valid(addr_valid), .addr(addr), .addr_par(addr_par),
        .cmd(cmd), .cmd_par(cmd_par),
        .data_valid(data_valid), .data(data), .data_ecc(data_ecc),
        .data_out_valid(data_out_valid), .data_out(data_out),
        .addr_perr(addr_perr), .cmd_perr(cmd_perr),
        .sbe(sbe), .dbe(dbe), .mbe(mbe), .err_pos(err_pos),
        .stk_addr_perr(stk_addr_perr), .stk_cmd_perr(stk_cmd_perr),
        .stk_sbe(stk_sbe), .stk_dbe(stk_dbe), .stk_mbe(stk_mbe),
        .blk_done(blk_done), .blk_err(blk_err), .blk_uncorr(blk_uncorr),
        .first_vld(first_vld), .first_syn(first_syn), .first_beat(first_beat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // position of data bit i: walk the positions, skipping powers of two
    function automatic int tb_pos(input int i);
        int n = 0;
        for (int p = 1; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == i) return p;
                n++;
            end
        end
        return 0;
    endfunction

    function automatic logic [7:0] tb_encode(input logic [63:0] d);
        int s = 0;
        logic [7:0] c;
        for (int i = 0; i < 64; i++) if (d[i]) s = s ^ tb_pos(i);
        c[6:0] = 7'(s);
        c[7]   = (^d) ^ (^c[6:0]);
        return c;
    endfunction

    // returns {overall parity, syndrome}
    function automatic logic [7:0] tb_decode(input logic [63:0] d, input logic [7:0] c);
        int s = 0;
        for (int i = 0; i < 64; i++) if (d[i]) s = s ^ tb_pos(i);
        for (int k = 0; k < 7; k++) if (c[k]) s = s ^ (1 << k);
        return {(^d) ^ (^c), 7'(s)};
    endfunction

    // reference model, advanced on the same edge as the design
    bit         m_ap, m_cp, m_sbe, m_dbe, m_mbe;
    bit [6:0]   m_pos;
    bit         m_sa, m_sc, m_ss, m_sd, m_sm;
    bit         m_dvld;
    bit [63:0]  m_dout;
    int         m_cnt;
    bit         m_acc_e, m_acc_u, m_done, m_berr, m_bunc, m_fvld;
    bit [7:0]   m_fsyn;
    int         m_fbeat;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_ap, m_cp, m_sbe, m_dbe, m_mbe, m_sa, m_sc, m_ss, m_sd, m_sm} = '0;
            m_pos = 0; m_dvld = 0; m_dout = 0; m_cnt = 0;
            m_acc_e = 0; m_acc_u = 0; m_done = 0; m_berr = 0; m_bunc = 0;
            m_fvld = 0; m_fsyn = 0; m_fbeat = 0;
        end else begin
            logic [7:0] r;
            bit e, u;
            m_ap  = addr_valid && ((^addr) ^ addr_par);
            m_cp  = addr_valid && ((^cmd) ^ cmd_par);
            m_sbe = 0; m_dbe = 0; m_mbe = 0; m_pos = 0; m_done = 0;
            m_dvld = data_valid;
            if (data_valid) begin
                m_dout = data;
                r = tb_decode(data, data_ecc);
                if (r[7]) begin
                    if (r[6:0] <= 71) begin m_sbe = 1; m_pos = r[6:0]; end
                    else m_mbe = 1;
                end else if (r[6:0] != 0) m_dbe = 1;
                e = m_sbe | m_dbe | m_mbe;
                u = m_dbe | m_mbe;
                if (m_cnt == 0) begin
                    m_acc_e = 0; m_acc_u = 0; m_fvld = 0; m_fsyn = 0; m_fbeat = 0;
                end
                if (e && !m_fvld) begin m_fvld = 1; m_fsyn = r; m_fbeat = m_cnt; end
                m_acc_e |= e;
                m_acc_u |= u;
                if (m_cnt == BEATS - 1) begin
                    m_done = 1; m_berr = m_acc_e; m_bunc = m_acc_u; m_cnt = 0;
                end else m_cnt++;
            end
            if (clr) {m_sa, m_sc, m_ss, m_sd, m_sm} = '0;
            m_sa |= m_ap; m_sc |= m_cp; m_ss |= m_sbe; m_sd |= m_dbe; m_sm |= m_mbe;
        end
    end

    // cycle-by-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(addr_perr === m_ap, "R2", "addr_perr", 64'(addr_perr), 64'(m_ap));
            chk(cmd_perr === m_cp, "R3", "cmd_perr", 64'(cmd_perr), 64'(m_cp));
            chk(data_out_valid === m_dvld && data_out === m_dout, "R4", "data_out",
                data_out, m_dout);
            chk(sbe === m_sbe && err_pos === m_pos, "R6", "sbe/err_pos",
                {56'(sbe), 1'b0, err_pos}, {56'(m_sbe), 1'b0, m_pos});
            chk(dbe === m_dbe, "R7", "dbe", 64'(dbe), 64'(m_dbe));
            chk(mbe === m_mbe, "R8", "mbe", 64'(mbe), 64'(m_mbe));
            chk({stk_addr_perr, stk_cmd_perr, stk_sbe, stk_dbe, stk_mbe} ===
                {m_sa, m_sc, m_ss, m_sd, m_sm}, "R9", "sticky",
                64'({stk_addr_perr, stk_cmd_perr, stk_sbe, stk_dbe, stk_mbe}),
                64'({m_sa, m_sc, m_ss, m_sd, m_sm}));
            chk({blk_done, blk_err, blk_uncorr} === {m_done, m_berr, m_bunc}, "R10",
                "block summary", 64'({blk_done, blk_err, blk_uncorr}),
                64'({m_done, m_berr, m_bunc}));
            chk(first_vld === m_fvld && first_syn === m_fsyn && first_beat === 3'(m_fbeat),
                "R11", "first capture", {52'(first_vld), first_syn, 1'b0, first_beat},
                {52'(m_fvld), m_fsyn, 1'b0, 3'(m_fbeat)});
        end
    end

    task automatic addr_cycle(input logic [ADDR_W-1:0] a, input logic [CMD_W-1:0] c,
                              input bit fa, input bit fc, input bit v);
        addr = a; addr_par = (^a) ^ fa;
        cmd = c;  cmd_par = (^c) ^ fc;
        addr_valid = v;
        @(negedge clk);
        addr_valid = 0;
    endtask

    task automatic beat(input logic [63:0] d, input logic [71:0] flip);
        data = d ^ flip[63:0];
        data_ecc = tb_encode(d) ^ flip[71:64];
        data_valid = 1;
        @(negedge clk);
        data_valid = 0;
    endtask

    function automatic logic [63:0] word(input int i);
        return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
    endfunction

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; clr = 0; addr_valid = 0; addr = 0; addr_par = 0;
        cmd = 0; cmd_par = 0; data_valid = 0; data = 0; data_ecc = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({addr_perr, cmd_perr, sbe, dbe, mbe, stk_addr_perr, stk_cmd_perr, stk_sbe,
             stk_dbe, stk_mbe, blk_done, blk_err, blk_uncorr, first_vld, data_out_valid} == 0
            && data_out == 0 && err_pos == 0 && first_syn == 0 && first_beat == 0,
            "R1", "outputs in reset", data_out, 0);
        rst_n = 1;
        @(negedge clk);
        chk(stk_sbe == 0 && blk_done == 0 && first_vld == 0, "R1", "after reset",
            64'({stk_sbe, blk_done, first_vld}), 0);

        // R2/R3: bad parity without strobe is ignored
        addr_cycle(40'hAB_CDEF_0123, 8'h5A, 1, 1, 0);
        chk(!addr_perr && !cmd_perr && !stk_addr_perr && !stk_cmd_perr, "R2",
            "unstrobed parity ignored", 64'({addr_perr, cmd_perr}), 0);
        addr_cycle(40'h12_3456_789A, 8'h3C, 0, 0, 1);
        chk(!addr_perr && !cmd_perr, "R2", "good parity", 64'({addr_perr, cmd_perr}), 0);
        addr_cycle(40'h12_3456_789B, 8'h3C, 1, 0, 1);
        chk(addr_perr && !cmd_perr, "R2", "address flip", 64'({addr_perr, cmd_perr}), 2);
        addr_cycle(40'h00_0000_0001, 8'hFF, 0, 1, 1);
        chk(!addr_perr && cmd_perr, "R3", "command flip", 64'({addr_perr, cmd_perr}), 1);
        addr_cycle(40'hFF_0000_0000, 8'h01, 1, 1, 1);
        chk(addr_perr && cmd_perr, "R3", "both flip", 64'({addr_perr, cmd_perr}), 3);
        @(negedge clk);
        chk(!addr_perr && !cmd_perr, "R2", "pulse is one cycle", 64'({addr_perr, cmd_perr}), 0);

        // R8: faulty data without strobe is ignored
        data = 64'hDEAD_BEEF; data_ecc = 8'hFF;
        @(negedge clk);
        chk(!sbe && !dbe && !mbe && !stk_sbe && !stk_dbe && !stk_mbe && !data_out_valid,
            "R8", "unstrobed data ignored", 64'({sbe, dbe, mbe}), 0);

        // block 1: clean, with an idle gap
        for (int i = 0; i < BEATS; i++) begin
            if (i == 4) @(negedge clk);
            beat(word(i), 72'h0);
            chk(!sbe && !dbe && !mbe, "R5", "clean word", 64'({sbe, dbe, mbe}), 0);
        end
        chk(blk_done && !blk_err && !blk_uncorr, "R10", "clean group",
            64'({blk_done, blk_err, blk_uncorr}), 4);
        chk(data_out == word(BEATS - 1), "R4", "last word passed", data_out, word(BEATS - 1));

        // block 2: single, double, single in check bit 2
        beat(word(10), 72'h0);
        beat(word(11), 72'h1 << 5);
        chk(sbe && err_pos == 7'd10, "R6", "data bit 5 at position 10", 64'(err_pos), 10);
        chk(data_out == (word(11) ^ 64'h20), "R4", "faulty word unmodified", data_out,
            word(11) ^ 64'h20);
        beat(word(12), 72'h3);
        chk(dbe && !sbe, "R7", "two data bits", 64'({sbe, dbe}), 1);
        beat(word(13), 72'h1 << 66);
        chk(sbe && err_pos == 7'd4, "R6", "check bit 2 at position 4", 64'(err_pos), 4);
        for (int i = 4; i < BEATS; i++) beat(word(10 + i), 72'h0);
        chk(blk_done && blk_err && blk_uncorr, "R10", "group with double",
            64'({blk_done, blk_err, blk_uncorr}), 7);
        chk(first_vld && first_beat == 1 && first_syn == 8'h8A, "R11", "first capture kept",
            64'(first_syn), 64'h8A);

        // block 3: multi, four-bit, overall bit
        beat(word(20), 72'h58 << 64);
        chk(mbe && !sbe && !dbe, "R8", "syndrome 88 is multi", 64'({sbe, dbe, mbe}), 1);
        beat(word(21), 72'hF);
        chk(dbe, "R7", "four data bits detected", 64'(dbe), 1);
        beat(word(22), 72'h1 << 71);
        chk(sbe && err_pos == 0, "R6", "overall bit at position 0", 64'(err_pos), 0);
        for (int i = 3; i < BEATS; i++) beat(word(20 + i), 72'h0);
        chk(first_beat == 0 && first_syn == 8'hD8, "R11", "first is beat 0",
            64'(first_syn), 64'hD8);
        chk(stk_addr_perr && stk_cmd_perr && stk_sbe && stk_dbe && stk_mbe, "R9",
            "all sticky set", 64'({stk_addr_perr, stk_cmd_perr, stk_sbe, stk_dbe, stk_mbe}), 31);

        // R9: clear, then clear colliding with a new error
        clr = 1;
        @(negedge clk);
        clr = 0;
        chk(!stk_addr_perr && !stk_cmd_perr && !stk_sbe && !stk_dbe && !stk_mbe, "R9",
            "clear", 64'({stk_addr_perr, stk_cmd_perr, stk_sbe, stk_dbe, stk_mbe}), 0);
        clr = 1;
        beat(word(30), 72'h1 << 9);
        clr = 0;
        chk(stk_sbe, "R9", "set wins over clear", 64'(stk_sbe), 1);
        for (int i = 1; i < BEATS; i++) beat(word(30 + i), 72'h0);
        chk(blk_done && blk_err && !blk_uncorr, "R10", "singles only",
            64'({blk_done, blk_err, blk_uncorr}), 6);

        // block 5: clean, capture cleared
        for (int i = 0; i < BEATS; i++) beat(word(40 + i), 72'h0);
        chk(!first_vld && !blk_err, "R11", "clean group clears capture",
            64'({first_vld, blk_err}), 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule